// File: doc/BRIEF.md
# Card Control Register Bank with Write Protection

This block holds the small set of control registers that a memory card exposes in its attribute space. The registers sit at even byte offsets from 4000h and cover a soft reset, a power-down command, a socket and copy identifier, a per-pair sleep selection and the write protection settings. A read-only card status byte gathers live bits from those registers, from the physical write-protect switch and from the ready/busy aggregator. The bus side is a simple synchronous strobe interface. An attribute-space select, an address, a write strobe and a read strobe arrive with byte write data, and the read data comes back one clock later.

The block also drives the qualifiers that the rest of the card uses. One output allows common-memory writes and one allows writes to the CIS area. Further outputs give the block-locking enable, the soft-reset level and one deep-power-down line per device pair. When the switch is in the protect position, both memory-write qualifiers are forced low. Register writes in attribute space still reach the control registers.

Top module: `card_ctrl_regs`

## Requirements
- R1: A synchronous high `rst` clears every register to 0. While it is high, all outputs are 0. Afterwards, reads of every register offset return 0 and `pair_pd` is 0.
- R2: Bit 7 of the option register at 4000h is the soft-reset flag. It reads back at bit 7 and drives `soft_rst`. Writing 1 sets it and writing 0 clears it.
- R3: While the soft-reset flag is 1, the configuration, socket/copy, write protection and sleep registers read as 0 and ignore writes. The flag itself keeps its value.
- R4: Bit 2 of the configuration register at 4002h is the power-down command. One clock after the registers change, `pair_pd[i]` is 1 exactly when power-down is 1 and sleep bit i is 1.
- R5: Sleep control starts at 4118h, with bit i of byte k selecting device pair 8k+i. Bits at or above NPAIRS read as 0.
- R6: The status byte at 4100h reads, from bit 7 to bit 0: `adm_in`, the OR of all sleep bits, soft-reset, common-memory protect, power-down, CIS protect, `wp_switch`, `rdy_in`. Writing to 4100h changes nothing.
- R7: The write protection register at 4104h holds block-lock enable in bit 2, common-memory protect in bit 1 and CIS protect in bit 0. Bit 2 drives `blk_lock_en` one clock after the write.
- R8: One clock after its inputs change, `cm_wr_ok` is 1 exactly when the switch is off and common-memory protect is 0. `cis_wr_ok` is 1 exactly when the switch is off and CIS protect is 0.
- R9: The switch does not block writes to the control registers.
- R10: The following have no effect on the registers: writes to odd addresses, writes to unused even offsets, and writes with `attr_sel` low. Reads of any of these return 0.
- R11: The socket/copy register at 4006h stores bits 6:0 (copy number in 6:4, socket number in 3:0). Its bit 7 reads 0.
- R12: If a read and a write hit the same offset in one cycle, the read returns the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high card reset |
| attr_sel | input | 1 | 1 selects attribute space |
| addr | input | AW | Byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| wp_switch | input | 1 | Physical write-protect switch, 1 = protect |
| rdy_in | input | 1 | 1 = all devices ready |
| adm_in | input | 1 | 1 = some ready/busy line is masked |
| rdata | output | 8 | Registered read data |
| soft_rst | output | 1 | Soft-reset level |
| cm_wr_ok | output | 1 | Common-memory write allowed |
| cis_wr_ok | output | 1 | CIS write allowed |
| blk_lock_en | output | 1 | Block locking enabled |
| pair_pd | output | NPAIRS | Deep power-down per device pair |

## Verification
A read and a write can hit the same register in one cycle. The bench raises both strobes together at the socket/copy offset and expects the old value on `rdata`, then reads again to see the new one. A second overlap is the switch turning on in the cycle in which a register write lands. That write must still take effect, and both memory-write qualifiers must fall on the following clock. The bench judges both overlaps only at the ports.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int OFF_OPT   = 'h4000;
  localparam int OFF_CFG   = 'h4002;
  localparam int OFF_SOCK  = 'h4006;
  localparam int OFF_STAT  = 'h4100;
  localparam int OFF_WPROT = 'h4104;
  localparam int OFF_SLEEP = 'h4118;

  typedef struct packed {
    logic opt;
    logic cfg;
    logic sock;
    logic stat;
    logic wprot;
  } fix_sel_t;
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int AW        = 15,
  parameter int SLP_BYTES = 1
) (
  input  logic                 attr_sel,
  input  logic [AW-1:0]        addr,
  output fix_sel_t             fsel,
  output logic [SLP_BYTES-1:0] ssel
);
  logic even_attr;
  assign even_attr = attr_sel && !addr[0];

  always_comb begin
    fsel       = '0;
    fsel.opt   = even_attr && (addr == AW'(OFF_OPT));
    fsel.cfg   = even_attr && (addr == AW'(OFF_CFG));
    fsel.sock  = even_attr && (addr == AW'(OFF_SOCK));
    fsel.stat  = even_attr && (addr == AW'(OFF_STAT));
    fsel.wprot = even_attr && (addr == AW'(OFF_WPROT));
  end

  for (genvar b = 0; b < SLP_BYTES; b++) begin : g_slp
    assign ssel[b] = even_attr && (addr == AW'(OFF_SLEEP + 2 * b));
  end

  always_comb begin
    assert ($onehot0({fsel, ssel}))
      else $error("p_onehot_sel_r10: several register selects at once");
  end
endmodule

// File: rtl/ccr_regs.sv
module ccr_regs
  import ccr_pkg::*;
#(
  parameter int NPAIRS    = 6,
  parameter int SLP_BYTES = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  fix_sel_t             fsel,
  input  logic [SLP_BYTES-1:0] ssel,
  input  logic [7:0]           wdata,
  output logic                 sreset_q,
  output logic                 pwdn_q,
  output logic [6:0]           sock_q,
  output logic [2:0]           wprot_q,
  output logic [NPAIRS-1:0]    sleep_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sreset_q <= 1'b0;
    end else if (wr_en && fsel.opt) begin
      sreset_q <= wdata[7];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sreset_q) begin
      pwdn_q  <= 1'b0;
      sock_q  <= '0;
      wprot_q <= '0;
      sleep_q <= '0;
    end else if (wr_en) begin
      if (fsel.cfg)   pwdn_q  <= wdata[2];
      if (fsel.sock)  sock_q  <= wdata[6:0];
      if (fsel.wprot) wprot_q <= wdata[2:0];
      for (int i = 0; i < NPAIRS; i++) begin
        if (ssel[i/8]) sleep_q[i] <= wdata[i%8];
      end
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $past(sreset_q) |-> (!pwdn_q && sock_q == '0 && wprot_q == '0 && sleep_q == '0));

  p_stat_ro_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fsel.stat && !sreset_q) |=>
      ($stable(pwdn_q) && $stable(sock_q) && $stable(wprot_q) && $stable(sleep_q) && $stable(sreset_q)));

  p_noattr_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fsel == '0 && ssel == '0) |=>
      ($stable(sreset_q) && $stable(pwdn_q) && $stable(sock_q) && $stable(wprot_q) && $stable(sleep_q)));
endmodule

// File: rtl/ccr_out.sv
module ccr_out
  import ccr_pkg::*;
#(
  parameter int NPAIRS    = 6,
  parameter int SLP_BYTES = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  fix_sel_t             fsel,
  input  logic [SLP_BYTES-1:0] ssel,
  input  logic                 sreset_q,
  input  logic                 pwdn_q,
  input  logic [6:0]           sock_q,
  input  logic [2:0]           wprot_q,
  input  logic [NPAIRS-1:0]    sleep_q,
  input  logic                 wp_switch,
  input  logic                 rdy_in,
  input  logic                 adm_in,
  output logic [7:0]           rdata,
  output logic                 cm_wr_ok,
  output logic                 cis_wr_ok,
  output logic                 blk_lock_en,
  output logic [NPAIRS-1:0]    pair_pd
);
  localparam int SLP_W = SLP_BYTES * 8;

  logic [SLP_W-1:0] slp_pad;
  logic [7:0]       status;
  logic [7:0]       rd_mux;

  assign slp_pad = SLP_W'(sleep_q);
  assign status  = {adm_in, |sleep_q, sreset_q, wprot_q[1], pwdn_q, wprot_q[0], wp_switch, rdy_in};

  always_comb begin
    rd_mux = '0;
    if (fsel.opt)   rd_mux = {sreset_q, 7'b0};
    if (fsel.cfg)   rd_mux = {5'b0, pwdn_q, 2'b0};
    if (fsel.sock)  rd_mux = {1'b0, sock_q};
    if (fsel.stat)  rd_mux = status;
    if (fsel.wprot) rd_mux = {5'b0, wprot_q};
    for (int b = 0; b < SLP_BYTES; b++) begin
      if (ssel[b]) rd_mux = slp_pad[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      cm_wr_ok    <= 1'b0;
      cis_wr_ok   <= 1'b0;
      blk_lock_en <= 1'b0;
      pair_pd     <= '0;
    end else begin
      rdata       <= rd_en ? rd_mux : 8'h00;
      cm_wr_ok    <= !wp_switch && !wprot_q[1];
      cis_wr_ok   <= !wp_switch && !wprot_q[0];
      blk_lock_en <= wprot_q[2];
      pair_pd     <= sleep_q & {NPAIRS{pwdn_q}};
    end
  end

  p_pd_needs_pwdn_r4: assert property (@(posedge clk) disable iff (rst)
    (|pair_pd) |-> $past(pwdn_q));

  p_switch_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (cm_wr_ok || cis_wr_ok) |-> !$past(wp_switch));

  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == 8'h00));

  p_bitseven_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fsel.sock) |=> !rdata[7]);
endmodule

// File: rtl/card_ctrl_regs.sv
module card_ctrl_regs
  import ccr_pkg::*;
#(
  parameter int AW     = 15,
  parameter int NPAIRS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              attr_sel,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  input  logic              wp_switch,
  input  logic              rdy_in,
  input  logic              adm_in,
  output logic [7:0]        rdata,
  output logic              soft_rst,
  output logic              cm_wr_ok,
  output logic              cis_wr_ok,
  output logic              blk_lock_en,
  output logic [NPAIRS-1:0] pair_pd
);
  localparam int SLP_BYTES = (NPAIRS + 7) / 8;

  fix_sel_t              fsel;
  logic [SLP_BYTES-1:0]  ssel;
  logic                  sreset_q;
  logic                  pwdn_q;
  logic [6:0]            sock_q;
  logic [2:0]            wprot_q;
  logic [NPAIRS-1:0]     sleep_q;

  ccr_decode #(.AW(AW), .SLP_BYTES(SLP_BYTES)) u_dec (
    .attr_sel(attr_sel), .addr(addr), .fsel(fsel), .ssel(ssel)
  );

  ccr_regs #(.NPAIRS(NPAIRS), .SLP_BYTES(SLP_BYTES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .fsel(fsel), .ssel(ssel), .wdata(wdata),
    .sreset_q(sreset_q), .pwdn_q(pwdn_q), .sock_q(sock_q), .wprot_q(wprot_q),
    .sleep_q(sleep_q)
  );

  ccr_out #(.NPAIRS(NPAIRS), .SLP_BYTES(SLP_BYTES)) u_out (
    .clk(clk), .rst(rst), .rd_en(rd_en), .fsel(fsel), .ssel(ssel),
    .sreset_q(sreset_q), .pwdn_q(pwdn_q), .sock_q(sock_q), .wprot_q(wprot_q),
    .sleep_q(sleep_q), .wp_switch(wp_switch), .rdy_in(rdy_in), .adm_in(adm_in),
    .rdata(rdata), .cm_wr_ok(cm_wr_ok), .cis_wr_ok(cis_wr_ok),
    .blk_lock_en(blk_lock_en), .pair_pd(pair_pd)
  );

  assign soft_rst = sreset_q;

  p_switch_keeps_regs_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fsel.opt) |=> (soft_rst == $past(wdata[7])));

  p_reset_clears_r1: assert property (@(posedge clk)
    $past(rst) |-> (!soft_rst && pair_pd == '0 && !cm_wr_ok && !cis_wr_ok));
endmodule

// File: tb/card_ctrl_regs_tb.sv
`timescale 1ns/1ps
module card_ctrl_regs_tb;
  localparam int AW = 15;
  localparam int NP = 6;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          attr_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic          wp_switch = 1'b0;
  logic          rdy_in = 1'b1;
  logic          adm_in = 1'b0;
  logic [7:0]    rdata;
  logic          soft_rst, cm_wr_ok, cis_wr_ok, blk_lock_en;
  logic [NP-1:0] pair_pd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  card_ctrl_regs #(.AW(AW), .NPAIRS(NP)) u_dut (
    .clk(clk), .rst(rst), .attr_sel(attr_sel), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .wp_switch(wp_switch), .rdy_in(rdy_in),
    .adm_in(adm_in), .rdata(rdata), .soft_rst(soft_rst), .cm_wr_ok(cm_wr_ok),
    .cis_wr_ok(cis_wr_ok), .blk_lock_en(blk_lock_en), .pair_pd(pair_pd)
  );

  // op: 0 write, 1 read and compare, 2 read+write same cycle and compare
  localparam logic [32:0] VEC [NV] = '{
    {2'd0, 15'h4002, 8'h04, 8'h00},
    {2'd1, 15'h4002, 8'h00, 8'h04},
    {2'd0, 15'h4118, 8'hFF, 8'h00},
    {2'd1, 15'h4118, 8'h00, 8'h3F},
    {2'd0, 15'h4006, 8'hFF, 8'h00},
    {2'd1, 15'h4006, 8'h00, 8'h7F},
    {2'd0, 15'h4104, 8'h07, 8'h00},
    {2'd1, 15'h4104, 8'h00, 8'h07},
    {2'd1, 15'h4100, 8'h00, 8'h5D},
    {2'd0, 15'h4100, 8'h00, 8'h00},
    {2'd1, 15'h4100, 8'h00, 8'h5D},
    {2'd0, 15'h4003, 8'hFF, 8'h00},
    {2'd1, 15'h4002, 8'h00, 8'h04},
    {2'd1, 15'h4003, 8'h00, 8'h00},
    {2'd0, 15'h4010, 8'hFF, 8'h00},
    {2'd1, 15'h4010, 8'h00, 8'h00},
    {2'd2, 15'h4006, 8'h15, 8'h7F},
    {2'd1, 15'h4006, 8'h00, 8'h15},
    {2'd0, 15'h4104, 8'h00, 8'h00},
    {2'd1, 15'h4104, 8'h00, 8'h00}
  };
  localparam string TAG [NV] = '{
    "", "R4", "", "R5", "", "R11", "", "R7", "R6", "", "R6", "", "R10", "R10",
    "", "R10", "R12", "R12", "", "R7"
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic a, input logic [AW-1:0] ad, input logic w,
                        input logic r, input logic [7:0] d);
    @(negedge clk);
    attr_sel = a; addr = ad; wr_en = w; rd_en = r; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; attr_sel = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] ad, input logic [7:0] d);
    access(1'b1, ad, 1'b1, 1'b0, d);
  endtask

  task automatic rd_chk(input logic [AW-1:0] ad, input int exp, input string req);
    access(1'b1, ad, 1'b0, 1'b1, 8'h00);
    check(req, rdata, exp);
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 outputs in reset", {soft_rst, cm_wr_ok, cis_wr_ok, blk_lock_en, pair_pd}, 0);
    rst = 1'b0;
    settle();
    rd_chk(15'h4000, 8'h00, "R1");
    rd_chk(15'h4104, 8'h00, "R1");
    check("R8 after reset cm", cm_wr_ok, 1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][32:31];
      if (op == 2'd0) wr(VEC[i][30:16], VEC[i][15:8]);
      else if (op == 2'd1) rd_chk(VEC[i][30:16], VEC[i][7:0], TAG[i]);
      else begin
        access(1'b1, VEC[i][30:16], 1'b1, 1'b1, VEC[i][15:8]);
        check(TAG[i], rdata, VEC[i][7:0]);
      end
    end

    // R4: power-down with sleep selection
    wr(15'h4002, 8'h04);
    settle();
    check("R4 all selected", pair_pd, 6'h3F);
    wr(15'h4118, 8'h05);
    settle();
    check("R4 subset", pair_pd, 6'h05);
    wr(15'h4002, 8'h00);
    settle();
    check("R4 pwdn off", pair_pd, 6'h00);

    // R8 / R7: qualifiers
    check("R8 both open cm", cm_wr_ok, 1);
    check("R8 both open cis", cis_wr_ok, 1);
    wr(15'h4104, 8'h02);
    settle();
    check("R8 cm protect cm", cm_wr_ok, 0);
    check("R8 cm protect cis", cis_wr_ok, 1);
    wr(15'h4104, 8'h01);
    settle();
    check("R8 cis protect cm", cm_wr_ok, 1);
    check("R8 cis protect cis", cis_wr_ok, 0);
    wr(15'h4104, 8'h04);
    settle();
    check("R7 block lock", blk_lock_en, 1);

    // R9: switch turns on in the cycle of a register write
    @(negedge clk);
    wp_switch = 1'b1;
    attr_sel = 1'b1; addr = 15'h4006; wr_en = 1'b1; wdata = 8'h12;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; attr_sel = 1'b0;
    check("R8 switch cm", cm_wr_ok, 0);
    check("R8 switch cis", cis_wr_ok, 0);
    rd_chk(15'h4006, 8'h12, "R9");
    rd_chk(15'h4100, 8'h43, "R6 switch bit");

    // R2 / R3: soft reset
    wr(15'h4000, 8'h80);
    check("R2 soft_rst on", soft_rst, 1);
    rd_chk(15'h4000, 8'h80, "R2");
    rd_chk(15'h4006, 8'h00, "R3 cleared");
    wr(15'h4006, 8'h33);
    rd_chk(15'h4006, 8'h00, "R3 ignored");
    rd_chk(15'h4000, 8'h80, "R3 flag kept");
    wr(15'h4000, 8'h00);
    check("R2 soft_rst off", soft_rst, 0);
    rd_chk(15'h4104, 8'h00, "R3 after");

    // R10: common-space access
    wr(15'h4006, 8'h21);
    access(1'b0, 15'h4006, 1'b1, 1'b0, 8'h55);
    rd_chk(15'h4006, 8'h21, "R10 common write");
    access(1'b0, 15'h4006, 1'b0, 1'b1, 8'h00);
    check("R10 common read", rdata, 0);

    // R1: reset after activity
    wr(15'h4002, 8'h04);
    wr(15'h4118, 8'h3F);
    @(negedge clk); rst = 1'b1;
    settle();
    @(negedge clk); rst = 1'b0;
    settle();
    check("R1 pair_pd", pair_pd, 0);
    rd_chk(15'h4118, 8'h00, "R1 sleep");
    rd_chk(15'h4002, 8'h00, "R1 cfg");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule